// File: doc/BRIEF.md
# Load-Store Data Alignment Unit

This block sits between a processor's load-store pipe and a data memory that is one 32-bit word wide. Each access arrives as a base register value, a signed 16-bit displacement, a size and a direction. The unit adds the base and the sign-extended displacement to form the effective address. It decides which byte lanes of the memory word take part and presents the request to memory one clock later. A zero displacement gives plain register-indirect access.

For stores, the unit copies the low byte or low halfword of the source operand onto every matching lane, so the byte enables alone pick the target. For loads, it remembers the size, the lane offset and the signedness of the most recent issued load. When the memory word comes back, it takes the addressed byte or halfword and widens it to a full 32-bit result, with sign or zero fill. Lanes are big-endian: byte offset 0 is bits 31..24 of the memory word. A halfword at an odd address, or a word at an address that is not a multiple of four, is rejected with an address-error pulse and reaches no memory at all.

Top module: `lsu_align`

## Requirements
- R1: The effective address is `req_base` plus `req_disp` sign-extended to 32 bits, with wrap modulo 2^32. An accepted request appears on `mem_valid`/`mem_write`/`mem_addr` in the cycle after `req_valid` is sampled high.
- R2: A byte access (`req_size`=00) asserts exactly one enable. Offset k (address bits 1..0) drives `mem_be[3-k]`, so offset 0 maps to bits 31..24.
- R3: A halfword access (`req_size`=01) asserts `mem_be`=1100 at offset 0 and `mem_be`=0011 at offset 2.
- R4: A word access (`req_size`=10) asserts `mem_be`=1111.
- R5: Store data is replicated onto the lanes. A byte store drives four copies of `req_wdata[7:0]`, a halfword store drives two copies of `req_wdata[15:0]`, and a word store drives `req_wdata` unchanged. The upper source bits of a sub-word store have no effect.
- R6: A signed byte or halfword load (`req_unsigned`=0) returns the addressed field sign-extended to 32 bits.
- R7: An unsigned byte or halfword load (`req_unsigned`=1) returns the addressed field zero-extended to 32 bits.
- R8: A word load returns the whole memory word, whatever the value of `req_unsigned`.
- R9: A halfword request with address bit 0 set, or a word request with either of address bits 1..0 set, pulses `addr_err` one cycle later and produces no `mem_valid`.
- R10: During reset, `mem_valid`, `ld_valid` and `addr_err` are low.
- R11: `ld_valid` rises exactly one cycle after `mem_rvalid` is high. `ld_data` is formed with the attributes of the most recent accepted load, and those attributes stay in force for any later responses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request strobe |
| req_write | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | 00 byte, 01 halfword, 10 word (11 handled as word) |
| req_unsigned | input | 1 | Zero-extend sub-word load result |
| req_base | input | 32 | Base register value |
| req_disp | input | 16 | Signed displacement |
| req_wdata | input | 32 | Store source register value |
| mem_valid | output | 1 | Memory access strobe |
| mem_write | output | 1 | Memory write |
| mem_addr | output | 32 | Effective byte address |
| mem_be | output | 4 | Byte-lane enables, bit 3 = bits 31..24 |
| mem_wdata | output | 32 | Lane-replicated store data |
| mem_rvalid | input | 1 | Load word returned |
| mem_rdata | input | 32 | Returned memory word |
| ld_valid | output | 1 | Load result strobe |
| ld_data | output | 32 | Extended load result |
| addr_err | output | 1 | Misaligned access pulse |

## Verification
The bench sweeps every size, direction and signedness against bases and displacements that cover all four lane offsets, negative displacements, the two displacement extremes and a wrap past 2^32. If the displacement were zero-extended, negative offsets would give wrong addresses. If the lanes were mirrored, offset 0 would land in bits 7..0. Each load is returned twice, with byte patterns of both sign polarities. A design that mixed up sign and zero fill, or lost the held attributes, would give a wrong upper result. Misaligned halfword and word requests check that the error pulses and that no memory strobe leaks through.

// File: rtl/lsu_pkg.sv
package lsu_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_RSVD = 2'b11
    } size_e;

endpackage

// File: rtl/lsu_agen.sv
module lsu_agen
    import lsu_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DISP_W = 16,
    parameter int OFF_W  = 2
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [DISP_W-1:0] disp,
    input  size_e             size,
    output logic [ADDR_W-1:0] ea,
    output logic              misaligned
);
    localparam int EXT_W = ADDR_W - DISP_W;

    logic [OFF_W-1:0] off;

    always_comb begin
        ea  = base + {{EXT_W{disp[DISP_W-1]}}, disp};
        off = ea[OFF_W-1:0];
        case (size)
            SZ_BYTE: misaligned = 1'b0;
            SZ_HALF: misaligned = off[0];
            default: misaligned = (off != '0);
        endcase
    end
endmodule

// File: rtl/lsu_store_lane.sv
module lsu_store_lane
    import lsu_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int LANES  = DATA_W / 8,
    parameter int OFF_W  = $clog2(LANES)
) (
    input  size_e             size,
    input  logic [OFF_W-1:0]  off,
    input  logic [DATA_W-1:0] wdata,
    output logic [LANES-1:0]  be,
    output logic [DATA_W-1:0] wdata_rep
);
    logic [DATA_W-1:0] rep_byte;
    logic [DATA_W-1:0] rep_half;

    for (genvar g = 0; g < LANES; g++) begin : g_rep_b
        assign rep_byte[g*8 +: 8] = wdata[7:0];
    end
    for (genvar g = 0; g < LANES / 2; g++) begin : g_rep_h
        assign rep_half[g*16 +: 16] = wdata[15:0];
    end

    always_comb begin
        for (int k = 0; k < LANES; k++) begin
            case (size)
                SZ_BYTE: be[LANES-1-k] = (int'(off) == k);
                SZ_HALF: be[LANES-1-k] = ((int'(off) >> 1) == (k >> 1));
                default: be[LANES-1-k] = 1'b1;
            endcase
        end
        case (size)
            SZ_BYTE: wdata_rep = rep_byte;
            SZ_HALF: wdata_rep = rep_half;
            default: wdata_rep = wdata;
        endcase
    end
endmodule

// File: rtl/lsu_load_extract.sv
module lsu_load_extract
    import lsu_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int LANES  = DATA_W / 8,
    parameter int OFF_W  = $clog2(LANES)
) (
    input  size_e             size,
    input  logic [OFF_W-1:0]  off,
    input  logic              uns,
    input  logic [DATA_W-1:0] word,
    output logic [DATA_W-1:0] result
);
    logic [DATA_W-1:0] sh_b;
    logic [DATA_W-1:0] sh_h;
    logic [7:0]        fld_b;
    logic [15:0]       fld_h;
    int                off_b;
    int                off_h;

    always_comb begin
        off_b = int'(off);
        off_h = int'({off[OFF_W-1:1], 1'b0});
        sh_b  = word >> (8 * (LANES - 1 - off_b));
        sh_h  = word >> (8 * (LANES - 2 - off_h));
        fld_b = sh_b[7:0];
        fld_h = sh_h[15:0];
        case (size)
            SZ_BYTE: result = {{(DATA_W-8){fld_b[7] & ~uns}}, fld_b};
            SZ_HALF: result = {{(DATA_W-16){fld_h[15] & ~uns}}, fld_h};
            default: result = word;
        endcase
    end
endmodule

// File: rtl/lsu_align.sv
module lsu_align
    import lsu_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int DISP_W = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    input  logic                   req_write,
    input  logic [1:0]             req_size,
    input  logic                   req_unsigned,
    input  logic [ADDR_W-1:0]      req_base,
    input  logic [DISP_W-1:0]      req_disp,
    input  logic [DATA_W-1:0]      req_wdata,
    output logic                   mem_valid,
    output logic                   mem_write,
    output logic [ADDR_W-1:0]      mem_addr,
    output logic [DATA_W/8-1:0]    mem_be,
    output logic [DATA_W-1:0]      mem_wdata,
    input  logic                   mem_rvalid,
    input  logic [DATA_W-1:0]      mem_rdata,
    output logic                   ld_valid,
    output logic [DATA_W-1:0]      ld_data,
    output logic                   addr_err
);
    localparam int LANES = DATA_W / 8;
    localparam int OFF_W = $clog2(LANES);

    typedef struct packed {
        logic              mem_valid;
        logic              mem_write;
        logic [ADDR_W-1:0] mem_addr;
        logic [LANES-1:0]  mem_be;
        logic [DATA_W-1:0] mem_wdata;
        logic              addr_err;
        logic [OFF_W-1:0]  pend_off;
        size_e             pend_size;
        logic              pend_uns;
        logic              ld_valid;
        logic [DATA_W-1:0] ld_data;
    } state_t;

    state_t st_d, st_q;

    size_e             size_in;
    logic [ADDR_W-1:0] ea;
    logic              misaligned;
    logic [LANES-1:0]  be_new;
    logic [DATA_W-1:0] wdata_new;
    logic [DATA_W-1:0] ld_ext;

    assign size_in = size_e'(req_size);

    lsu_agen #(.ADDR_W(ADDR_W), .DISP_W(DISP_W), .OFF_W(OFF_W)) agen_i (
        .base       (req_base),
        .disp       (req_disp),
        .size       (size_in),
        .ea         (ea),
        .misaligned (misaligned)
    );

    lsu_store_lane #(.DATA_W(DATA_W), .LANES(LANES), .OFF_W(OFF_W)) lane_i (
        .size      (size_in),
        .off       (ea[OFF_W-1:0]),
        .wdata     (req_wdata),
        .be        (be_new),
        .wdata_rep (wdata_new)
    );

    lsu_load_extract #(.DATA_W(DATA_W), .LANES(LANES), .OFF_W(OFF_W)) ext_i (
        .size   (st_q.pend_size),
        .off    (st_q.pend_off),
        .uns    (st_q.pend_uns),
        .word   (mem_rdata),
        .result (ld_ext)
    );

    always_comb begin
        st_d           = st_q;
        st_d.mem_valid = 1'b0;
        st_d.mem_write = 1'b0;
        st_d.addr_err  = 1'b0;
        st_d.ld_valid  = 1'b0;
        if (req_valid) begin
            if (misaligned) begin
                st_d.addr_err = 1'b1;
            end else begin
                st_d.mem_valid = 1'b1;
                st_d.mem_write = req_write;
                st_d.mem_addr  = ea;
                st_d.mem_be    = be_new;
                st_d.mem_wdata = wdata_new;
                if (!req_write) begin
                    st_d.pend_off  = ea[OFF_W-1:0];
                    st_d.pend_size = size_in;
                    st_d.pend_uns  = req_unsigned;
                end
            end
        end
        if (mem_rvalid) begin
            st_d.ld_valid = 1'b1;
            st_d.ld_data  = ld_ext;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mem_valid = st_q.mem_valid;
    assign mem_write = st_q.mem_write;
    assign mem_addr  = st_q.mem_addr;
    assign mem_be    = st_q.mem_be;
    assign mem_wdata = st_q.mem_wdata;
    assign ld_valid  = st_q.ld_valid;
    assign ld_data   = st_q.ld_data;
    assign addr_err  = st_q.addr_err;
endmodule

// File: rtl/lsu_align_chk.sv
module lsu_align_chk #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int DISP_W = 16
) (
    input logic                clk,
    input logic                rst_n,
    input logic                req_valid,
    input logic [1:0]          req_size,
    input logic [ADDR_W-1:0]   req_base,
    input logic [DISP_W-1:0]   req_disp,
    input logic                mem_valid,
    input logic                mem_write,
    input logic [ADDR_W-1:0]   mem_addr,
    input logic [DATA_W/8-1:0] mem_be,
    input logic                mem_rvalid,
    input logic                ld_valid,
    input logic                addr_err
);
    logic [ADDR_W-1:0] ea_chk;
    assign ea_chk = req_base + {{(ADDR_W-DISP_W){req_disp[DISP_W-1]}}, req_disp};

    a_r1_addr_sum: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> mem_addr == $past(ea_chk));

    a_r2_lane_count: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> ($countones(mem_be) == 1 || $countones(mem_be) == 2
                       || $countones(mem_be) == DATA_W / 8));

    a_r3_half_pair: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && $countones(mem_be) == 2) |->
            (mem_be == 4'b1100 || mem_be == 4'b0011));

    a_r4_word_all: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_size == 2'b10 && ea_chk[1:0] == 2'b00) |=>
            (mem_valid && mem_be == 4'b1111));

    a_r9_half_odd: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_size == 2'b01 && ea_chk[0]) |=> (addr_err && !mem_valid));

    a_r9_err_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        addr_err |-> !mem_valid && !mem_write);

    a_r11_ld_after_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        ld_valid |-> $past(mem_rvalid));
endmodule

bind lsu_align lsu_align_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DISP_W(DISP_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_size   (req_size),
    .req_base   (req_base),
    .req_disp   (req_disp),
    .mem_valid  (mem_valid),
    .mem_write  (mem_write),
    .mem_addr   (mem_addr),
    .mem_be     (mem_be),
    .mem_rvalid (mem_rvalid),
    .ld_valid   (ld_valid),
    .addr_err   (addr_err)
);

// File: tb/lsu_align_tb_top.sv
module lsu_align_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid, req_write, req_unsigned;
    logic [1:0]  req_size;
    logic [31:0] req_base, req_wdata;
    logic [15:0] req_disp;
    logic        mem_valid, mem_write, mem_rvalid, ld_valid, addr_err;
    logic [31:0] mem_addr, mem_wdata, mem_rdata, ld_data;
    logic [3:0]  mem_be;

    int n_cmp = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    lsu_align dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_size(req_size), .req_unsigned(req_unsigned), .req_base(req_base),
        .req_disp(req_disp), .req_wdata(req_wdata), .mem_valid(mem_valid),
        .mem_write(mem_write), .mem_addr(mem_addr), .mem_be(mem_be),
        .mem_wdata(mem_wdata), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .ld_valid(ld_valid), .ld_data(ld_data), .addr_err(addr_err)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
        summary();
    end

    function automatic logic [31:0] exp_load(input int sz, input bit un,
                                             input logic [1:0] off, input logic [31:0] w);
        logic [31:0] b, h;
        b = (w >> (24 - 8 * int'(off))) & 32'hFF;
        h = (w >> (16 - 8 * int'(off))) & 32'hFFFF;
        if (sz == 0) return (!un && b[7]) ? (b | 32'hFFFF_FF00) : b;
        if (sz == 1) return (!un && h[15]) ? (h | 32'hFFFF_0000) : h;
        return w;
    endfunction

    initial begin
        logic [31:0] bases [3];
        logic [15:0] disps [9];
        logic [31:0] pats  [2];
        bases[0] = 32'h0000_1000; bases[1] = 32'h7FFF_FFFD; bases[2] = 32'hFFFF_FFFE;
        disps[0] = 16'h0000; disps[1] = 16'h0001; disps[2] = 16'h0002;
        disps[3] = 16'h0003; disps[4] = 16'hFFFF; disps[5] = 16'hFFFE;
        disps[6] = 16'hFFFD; disps[7] = 16'h8000; disps[8] = 16'h7FFF;
        pats[0] = 32'h8A7B_F1C6; pats[1] = 32'h7F80_017E;

        rst_n = 1'b0; req_valid = 0; req_write = 0; req_unsigned = 0; req_size = 0;
        req_base = 0; req_disp = 0; req_wdata = 0; mem_rvalid = 0; mem_rdata = 0;
        repeat (3) @(negedge clk);
        chk(!mem_valid && !ld_valid && !addr_err, "R10 reset outputs low",
            {29'd0, mem_valid, ld_valid, addr_err}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int bi = 0; bi < 3; bi++)
        for (int di = 0; di < 9; di++)
        for (int sz = 0; sz < 3; sz++)
        for (int wr = 0; wr < 2; wr++)
        for (int un = 0; un < 2; un++) begin
            logic [31:0] ea, wd, exp_be, exp_wd;
            logic [1:0]  off;
            bit          mis;
            ea  = bases[bi] + {{16{disps[di][15]}}, disps[di]};
            off = ea[1:0];
            mis = (sz == 1 && off[0]) || (sz == 2 && off != 2'b00);
            wd  = 32'h9ABC_5E7F + 32'h0101_0101 * di;
            req_valid = 1; req_write = wr[0]; req_size = sz[1:0]; req_unsigned = un[0];
            req_base = bases[bi]; req_disp = disps[di]; req_wdata = wd;
            @(negedge clk);
            req_valid = 0;
            chk(!ld_valid, "R11 no result without response", {31'd0, ld_valid}, 32'd0);
            if (mis) begin
                chk(addr_err, "R9 misaligned error", {31'd0, addr_err}, 32'd1);
                chk(!mem_valid, "R9 access suppressed", {31'd0, mem_valid}, 32'd0);
            end else begin
                chk(mem_valid && !addr_err && mem_write == wr[0], "R1 request strobe",
                    {30'd0, mem_valid, mem_write}, {30'd0, 1'b1, wr[0]});
                chk(mem_addr == ea, "R1 effective address", mem_addr, ea);
                if (sz == 0) exp_be = 32'h8 >> off;
                else if (sz == 1) exp_be = 32'hC >> off;
                else exp_be = 32'hF;
                chk({28'd0, mem_be} == exp_be,
                    (sz == 0) ? "R2 byte lane" : (sz == 1) ? "R3 half lanes" : "R4 word lanes",
                    {28'd0, mem_be}, exp_be);
                if (wr == 1) begin
                    if (sz == 0) exp_wd = {4{wd[7:0]}};
                    else if (sz == 1) exp_wd = {2{wd[15:0]}};
                    else exp_wd = wd;
                    chk(mem_wdata == exp_wd, "R5 store replication", mem_wdata, exp_wd);
                end else begin
                    for (int p = 0; p < 2; p++) begin
                        logic [31:0] e;
                        mem_rvalid = 1; mem_rdata = pats[p];
                        @(negedge clk);
                        mem_rvalid = 0;
                        e = exp_load(sz, un[0], off, pats[p]);
                        chk(ld_valid, "R11 result strobe", {31'd0, ld_valid}, 32'd1);
                        chk(ld_data == e,
                            (sz == 2) ? "R8 word load" : (un == 1) ? "R7 zero extend" : "R6 sign extend",
                            ld_data, e);
                    end
                end
            end
            @(negedge clk);
        end
        summary();
    end
endmodule